// File: doc/BRIEF.md
# Compressed-to-Full Instruction Expander

This block turns one 16-bit compressed instruction into the equivalent 32-bit full-width instruction word, so that a core with a single full-width decoder can also run dense code. It is purely combinational. Each cycle it takes a 32-bit fetch word that holds two halfwords, picks the current one according to the byte order, and rewrites it. The top five bits pick a format class. Each class starts from a fixed base pattern, chosen from a small per-class table, and moves its register, immediate and offset fields to their full-width positions.

Besides the word, the block reports a status of decoded, undefined or branch-handled. Branch encodings are not expanded: the target arithmetic belongs to the fetch unit, which sees only the branch status. The output word is meaningful only when the status is decoded. In every other case it carries a fixed filler pattern, so that a consumer that ignores the status shows up at once.

Top module: `insn_expander`

## Requirements
- R1: With `bigEndian` high the current instruction is `fetchWord[31:16]`, otherwise it is `fetchWord[15:0]`; the other halfword never affects the outputs.
- R2: Classes 0 to 2 (bits 15:11) produce 0xE1B00000 with bits 12:11 at 6:5, bits 10:6 at 11:7, bits 5:3 at 3:0 and bits 2:0 at 15:12; every decoded word has 0xE in bits 31:28.
- R3: Class 3 takes its base from bits 10:9 (0:0xE0900000, 1:0xE0500000, 2:0xE2900000, 3:0xE2500000), with bits 8:6 at 2:0, bits 5:3 at 19:16 and bits 2:0 at 15:12.
- R4: Classes 4, 5, 6 and 7 use the bases 0xE3B00000, 0xE3500000, 0xE2900000 and 0xE2500000, keep the 8-bit immediate in bits 7:0, and copy bits 10:8 into both 19:16 and 15:12.
- R5: Class 8 with bit 10 clear indexes a 16-entry table by bits 9:6. There are four operand layouts: normal (Rd at 19:16 and 15:12, Rs at 3:0); register shift for entries 2, 3, 4 and 7 (Rd at 15:12 and 3:0, Rs at 11:8); negate for entry 9 (0xE2700000, Rd at 15:12, Rs at 19:16); multiply for entry 13 (0xE0100090, Rd at 19:16 and 11:8, Rs at 3:0).
- R6: Class 8 with bit 10 set extends the destination index with bit 7 and the source index with bit 6. Sub-ops 1 to 3 give add (0xE0800000), 5 to 7 give compare (0xE1500000) and 9 to 11 give move (0xE1A00000), each with D at 19:16 and 15:12 and S at 3:0. Sub-ops 12 and 13 give 0xE12FFF10 with bits 6:3 at 3:0. Sub-ops 0, 4 and 8 are undefined.
- R7: Sub-ops 14 and 15 of the high-register group give 0xE1200030 with the extended source index at 3:0 when `v5Enable` is high, and are undefined when it is low.
- R8: Loads and stores: class 9 gives 0xE59F0000; classes 18 and 19 give 0xE59D0000 when bit 11 is set and 0xE58D0000 otherwise, all three with bits 10:8 at 15:12 and the 8-bit offset times 4. Classes 10 and 11 pick from two four-entry tables by bit 9 and bits 11:10. Classes 12 to 15 scale the offset in bits 10:6 by 4 when bit 12 is clear and by 1 when it is set. Classes 16 and 17 put the offset times 2 into bits 11:8 and 3:0.
- R9: Classes 20 and 21 give 0xE28F0F00 or 0xE28D0F00, with bits 10:8 at 15:12 and the raw 8-bit immediate. Classes 22 and 23 with bits 11:8 equal to 0 give 0xE28DDF00, or 0xE24DDF00 when bit 7 is set, with the raw 7-bit offset.
- R10: Classes 22 and 23 with other values in bits 11:8 give a push/pop from {bit 11, bit 8} (0xE92D0000, 0xE92D4000, 0xE8BD0000, 0xE8BD8000) OR'd with the low byte; the value 0xE there gives 0xEF000000 OR'd with the parameter TRAP_CODE (default 0x00180000). Classes 24 and 25 give 0xE8B00000 or 0xE8A00000 with bits 10:8 at 19:16 and the mask. Classes 26 and 27 with bits 11:8 equal to 0xF give 0xEF000000 OR'd with the low byte.
- R11: Classes 26 and 27 with any other bits 11:8 value except 0xE report branch, and 0xE reports undefined. Classes 28, 30 and 31 report branch. Class 29 reports undefined when bit 0 is set and branch otherwise.
- R12: The status is 0 for decoded, 1 for undefined and 2 for branch, and never 3. Whenever the status is not 0 the word equals FILLER_WORD (default 0xBAADF00D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetchWord | input | 32 | Fetch word holding two compressed instructions |
| bigEndian | input | 1 | Selects the upper halfword as the current instruction |
| v5Enable | input | 1 | Allows the register link-exchange sub-ops |
| fullInsn | output | 32 | Expanded full-width instruction, or filler |
| status | output | 2 | 0 decoded, 1 undefined, 2 branch |

## Verification
Each format class is driven with register numbers that differ in every field, so a field moved to the wrong place or taken from the wrong bits gives a different word. Pairs that differ only in a table-select bit show whether the right base is picked: word versus byte scaling, load versus store, add versus subtract on the stack, and the four push/pop forms. The same instruction is placed once in each halfword of the fetch word, with a branch encoding in the other half, which separates a correct halfword select from a swapped one. Undefined and branch encodings, and the link-exchange sub-op with `v5Enable` low and high, show whether the filler and the status replace the word only where they should.

// File: rtl/insn_expander_pkg.sv
package insn_expander_pkg;

  localparam int HALF_W  = 16;
  localparam int WORD_W  = 32;
  localparam int CLASS_W = 5;

  typedef enum logic [1:0] {
    ST_DECODED = 2'd0,
    ST_UNDEF   = 2'd1,
    ST_BRANCH  = 2'd2
  } xstat_e;

  typedef enum logic [4:0] {
    L_NONE, L_SHIFTIMM, L_ADDSUB, L_IMM8, L_ALU_NORM, L_ALU_SHIFT,
    L_ALU_NEG, L_ALU_MUL, L_HIREG, L_BX, L_BLX, L_WIDEIMM, L_REGOFF,
    L_OFF_WORD, L_OFF_BYTE, L_HALF, L_ADDRGEN, L_STKADJ, L_MASK8, L_MULTI
  } layout_e;

  // strobes passed from the control to the datapath
  typedef struct packed {
    logic [WORD_W-1:0] baseWord;
    layout_e           layout;
    xstat_e            status;
  } xctl_t;

  function automatic logic [WORD_W-1:0] addSubBase(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'hE090_0000;
      2'd1:    return 32'hE050_0000;
      2'd2:    return 32'hE290_0000;
      default: return 32'hE250_0000;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] immOpBase(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'hE3B0_0000;
      2'd1:    return 32'hE350_0000;
      2'd2:    return 32'hE290_0000;
      default: return 32'hE250_0000;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] aluBase(input logic [3:0] op);
    case (op)
      4'd0:    return 32'hE010_0000;
      4'd1:    return 32'hE030_0000;
      4'd2:    return 32'hE1B0_0010;
      4'd3:    return 32'hE1B0_0030;
      4'd4:    return 32'hE1B0_0050;
      4'd5:    return 32'hE0B0_0000;
      4'd6:    return 32'hE0D0_0000;
      4'd7:    return 32'hE1B0_0070;
      4'd8:    return 32'hE110_0000;
      4'd9:    return 32'hE270_0000;
      4'd10:   return 32'hE150_0000;
      4'd11:   return 32'hE170_0000;
      4'd12:   return 32'hE190_0000;
      4'd13:   return 32'hE010_0090;
      4'd14:   return 32'hE1D0_0000;
      default: return 32'hE1F0_0000;
    endcase
  endfunction

  function automatic layout_e aluLayout(input logic [3:0] op);
    case (op)
      4'd2, 4'd3, 4'd4, 4'd7: return L_ALU_SHIFT;
      4'd9:                   return L_ALU_NEG;
      4'd13:                  return L_ALU_MUL;
      default:                return L_ALU_NORM;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] regOffBase(input logic ext, input logic [1:0] sel);
    if (!ext) begin
      case (sel)
        2'd0:    return 32'hE780_0000;
        2'd1:    return 32'hE7C0_0000;
        2'd2:    return 32'hE790_0000;
        default: return 32'hE7D0_0000;
      endcase
    end
    case (sel)
      2'd0:    return 32'hE180_00B0;
      2'd1:    return 32'hE190_00D0;
      2'd2:    return 32'hE190_00B0;
      default: return 32'hE190_00F0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] immOffBase(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'hE580_0000;
      2'd1:    return 32'hE590_0000;
      2'd2:    return 32'hE5C0_0000;
      default: return 32'hE5D0_0000;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] stackXferBase(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'hE92D_0000;
      2'd1:    return 32'hE92D_4000;
      2'd2:    return 32'hE8BD_0000;
      default: return 32'hE8BD_8000;
    endcase
  endfunction

endpackage

// File: rtl/insn_expander_ctl.sv
module insn_expander_ctl
  import insn_expander_pkg::*;
#(
  parameter logic [31:0] TRAP_CODE = 32'h0018_0000
) (
  input  logic [HALF_W-1:0] curHalf,
  input  logic              v5Enable,
  output xctl_t             ctl
);

  logic [CLASS_W-1:0] cls;
  assign cls = curHalf[HALF_W-1 -: CLASS_W];

  always_comb begin
    ctl.baseWord = '0;
    ctl.layout   = L_NONE;
    ctl.status   = ST_DECODED;
    case (cls)
      5'd0, 5'd1, 5'd2: begin
        ctl.baseWord = 32'hE1B0_0000;
        ctl.layout   = L_SHIFTIMM;
      end
      5'd3: begin
        ctl.baseWord = addSubBase(curHalf[10:9]);
        ctl.layout   = L_ADDSUB;
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        ctl.baseWord = immOpBase(curHalf[12:11]);
        ctl.layout   = L_IMM8;
      end
      5'd8: begin
        if (!curHalf[10]) begin
          ctl.baseWord = aluBase(curHalf[9:6]);
          ctl.layout   = aluLayout(curHalf[9:6]);
        end else begin
          case (curHalf[9:6])
            4'd1, 4'd2, 4'd3: begin
              ctl.baseWord = 32'hE080_0000;
              ctl.layout   = L_HIREG;
            end
            4'd5, 4'd6, 4'd7: begin
              ctl.baseWord = 32'hE150_0000;
              ctl.layout   = L_HIREG;
            end
            4'd9, 4'd10, 4'd11: begin
              ctl.baseWord = 32'hE1A0_0000;
              ctl.layout   = L_HIREG;
            end
            4'd12, 4'd13: begin
              ctl.baseWord = 32'hE12F_FF10;
              ctl.layout   = L_BX;
            end
            4'd14, 4'd15: begin
              if (v5Enable) begin
                ctl.baseWord = 32'hE120_0030;
                ctl.layout   = L_BLX;
              end else begin
                ctl.status = ST_UNDEF;
              end
            end
            default: ctl.status = ST_UNDEF;
          endcase
        end
      end
      5'd9: begin
        ctl.baseWord = 32'hE59F_0000;
        ctl.layout   = L_WIDEIMM;
      end
      5'd10, 5'd11: begin
        ctl.baseWord = regOffBase(curHalf[9], curHalf[11:10]);
        ctl.layout   = L_REGOFF;
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        ctl.baseWord = immOffBase(curHalf[12:11]);
        ctl.layout   = curHalf[12] ? L_OFF_BYTE : L_OFF_WORD;
      end
      5'd16, 5'd17: begin
        ctl.baseWord = curHalf[11] ? 32'hE1D0_00B0 : 32'hE1C0_00B0;
        ctl.layout   = L_HALF;
      end
      5'd18, 5'd19: begin
        ctl.baseWord = curHalf[11] ? 32'hE59D_0000 : 32'hE58D_0000;
        ctl.layout   = L_WIDEIMM;
      end
      5'd20, 5'd21: begin
        ctl.baseWord = curHalf[11] ? 32'hE28D_0F00 : 32'hE28F_0F00;
        ctl.layout   = L_ADDRGEN;
      end
      5'd22, 5'd23: begin
        if (curHalf[11:8] == 4'h0) begin
          ctl.baseWord = curHalf[7] ? 32'hE24D_DF00 : 32'hE28D_DF00;
          ctl.layout   = L_STKADJ;
        end else if (curHalf[11:8] == 4'hE) begin
          ctl.baseWord = 32'hEF00_0000 | TRAP_CODE;
          ctl.layout   = L_NONE;
        end else begin
          ctl.baseWord = stackXferBase({curHalf[11], curHalf[8]});
          ctl.layout   = L_MASK8;
        end
      end
      5'd24, 5'd25: begin
        ctl.baseWord = curHalf[11] ? 32'hE8B0_0000 : 32'hE8A0_0000;
        ctl.layout   = L_MULTI;
      end
      5'd26, 5'd27: begin
        if (curHalf[11:8] == 4'hF) begin
          ctl.baseWord = 32'hEF00_0000;
          ctl.layout   = L_MASK8;
        end else if (curHalf[11:8] == 4'hE) begin
          ctl.status = ST_UNDEF;
        end else begin
          ctl.status = ST_BRANCH;
        end
      end
      5'd29: ctl.status = curHalf[0] ? ST_UNDEF : ST_BRANCH;
      default: ctl.status = ST_BRANCH;
    endcase
  end

endmodule

// File: rtl/insn_expander_dp.sv
module insn_expander_dp
  import insn_expander_pkg::*;
#(
  parameter logic [31:0] FILLER_WORD = 32'hBAAD_F00D
) (
  input  logic [HALF_W-1:0] curHalf,
  input  xctl_t             ctl,
  output logic [WORD_W-1:0] fullInsn
);

  logic [2:0] rLo, rMid, rHi3, rTop;
  logic [3:0] hiD, hiS;
  logic [7:0] imm8;
  logic [4:0] off5;
  logic [WORD_W-1:0] fields;

  assign rLo  = curHalf[2:0];
  assign rMid = curHalf[5:3];
  assign rHi3 = curHalf[8:6];
  assign rTop = curHalf[10:8];
  assign hiD  = {curHalf[7], curHalf[2:0]};
  assign hiS  = {curHalf[6], curHalf[5:3]};
  assign imm8 = curHalf[7:0];
  assign off5 = curHalf[10:6];

  always_comb begin
    fields = '0;
    case (ctl.layout)
      L_SHIFTIMM:  fields = (32'(rLo) << 12) | (32'(off5) << 7)
                          | (32'(curHalf[12:11]) << 5) | 32'(rMid);
      L_ADDSUB:    fields = (32'(rMid) << 16) | (32'(rLo) << 12) | 32'(rHi3);
      L_IMM8:      fields = (32'(rTop) << 16) | (32'(rTop) << 12) | 32'(imm8);
      L_ALU_NORM:  fields = (32'(rLo) << 16) | (32'(rLo) << 12) | 32'(rMid);
      L_ALU_SHIFT: fields = (32'(rLo) << 12) | (32'(rMid) << 8) | 32'(rLo);
      L_ALU_NEG:   fields = (32'(rMid) << 16) | (32'(rLo) << 12);
      L_ALU_MUL:   fields = (32'(rLo) << 16) | (32'(rLo) << 8) | 32'(rMid);
      L_HIREG:     fields = (32'(hiD) << 16) | (32'(hiD) << 12) | 32'(hiS);
      L_BX:        fields = 32'(curHalf[6:3]);
      L_BLX:       fields = 32'(hiS);
      L_WIDEIMM:   fields = (32'(rTop) << 12) | (32'(imm8) << 2);
      L_REGOFF:    fields = (32'(rMid) << 16) | (32'(rLo) << 12) | 32'(rHi3);
      L_OFF_WORD:  fields = (32'(rMid) << 16) | (32'(rLo) << 12) | (32'(off5) << 2);
      L_OFF_BYTE:  fields = (32'(rMid) << 16) | (32'(rLo) << 12) | 32'(off5);
      L_HALF:      fields = (32'(rMid) << 16) | (32'(rLo) << 12)
                          | (32'(off5[4:3]) << 8) | (32'(off5[2:0]) << 1);
      L_ADDRGEN:   fields = (32'(rTop) << 12) | 32'(imm8);
      L_STKADJ:    fields = 32'(curHalf[6:0]);
      L_MASK8:     fields = 32'(imm8);
      L_MULTI:     fields = (32'(rTop) << 16) | 32'(imm8);
      default:     fields = '0;
    endcase
  end

  assign fullInsn = (ctl.status == ST_DECODED) ? (ctl.baseWord | fields) : FILLER_WORD;

endmodule

// File: rtl/insn_expander.sv
module insn_expander
  import insn_expander_pkg::*;
#(
  parameter logic [31:0] FILLER_WORD = 32'hBAAD_F00D,
  parameter logic [31:0] TRAP_CODE   = 32'h0018_0000
) (
  input  logic [31:0] fetchWord,
  input  logic        bigEndian,
  input  logic        v5Enable,
  output logic [31:0] fullInsn,
  output logic [1:0]  status
);

  logic [HALF_W-1:0] curHalf;
  xctl_t             ctl;

  assign curHalf = bigEndian ? fetchWord[WORD_W-1 -: HALF_W] : fetchWord[HALF_W-1:0];

  insn_expander_ctl #(.TRAP_CODE(TRAP_CODE)) u_ctl (
    .curHalf  (curHalf),
    .v5Enable (v5Enable),
    .ctl      (ctl)
  );

  insn_expander_dp #(.FILLER_WORD(FILLER_WORD)) u_dp (
    .curHalf  (curHalf),
    .ctl      (ctl),
    .fullInsn (fullInsn)
  );

  assign status = ctl.status;

endmodule

// File: rtl/insn_expander_chk.sv
module insn_expander_chk #(
  parameter logic [31:0] FILLER_WORD = 32'hBAAD_F00D
) (
  input logic [31:0] fetchWord,
  input logic        bigEndian,
  input logic        v5Enable,
  input logic [31:0] fullInsn,
  input logic [1:0]  status
);

  logic [15:0] pick;
  logic [4:0]  cls;
  logic        known;

  assign pick  = bigEndian ? fetchWord[31:16] : fetchWord[15:0];
  assign cls   = pick[15:11];
  assign known = !$isunknown({fetchWord, bigEndian, v5Enable});

  always_comb begin
    if (known) begin
      // R12
      status_code_chk: assert (status != 2'd3);
      // R12
      filler_chk: assert (status == 2'd0 || fullInsn == FILLER_WORD);
      // R2
      cond_field_chk: assert (status != 2'd0 || fullInsn[31:28] == 4'hE);
      // R11
      undef_src_chk: assert (status != 2'd1 || cls == 5'd8 || cls == 5'd26
                             || cls == 5'd27 || cls == 5'd29);
      // R11
      branch_cls_chk: assert (!(cls == 5'd28 || cls == 5'd30 || cls == 5'd31)
                              || status == 2'd2);
      // R7
      link_v5_chk: assert (v5Enable || !(cls == 5'd8 && pick[10] && pick[9:7] == 3'b111)
                           || status == 2'd1);
    end
  end

endmodule

bind insn_expander insn_expander_chk #(.FILLER_WORD(FILLER_WORD)) u_chk (
  .fetchWord (fetchWord),
  .bigEndian (bigEndian),
  .v5Enable  (v5Enable),
  .fullInsn  (fullInsn),
  .status    (status)
);

// File: tb/insn_expander_tb.sv
module insn_expander_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam logic [31:0] FILL = 32'hBAAD_F00D;

  typedef struct {
    logic [31:0] word;
    logic [1:0]  stat;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchWord = '0;
  logic        bigEndian = 1'b0;
  logic        v5Enable  = 1'b0;
  logic [31:0] fullInsn;
  logic [1:0]  status;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  exp_t sb[$];

  insn_expander u_dut (
    .fetchWord (fetchWord),
    .bigEndian (bigEndian),
    .v5Enable  (v5Enable),
    .fullInsn  (fullInsn),
    .status    (status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // driver: apply a stimulus and queue what it must produce
  task automatic drive(input logic [31:0] fw, input logic be, input logic v5,
                       input logic [31:0] expWord, input logic [1:0] expStat,
                       input string tag);
    @(posedge clk);
    #1;
    fetchWord = fw;
    bigEndian = be;
    v5Enable  = v5;
    sb.push_back('{word: expWord, stat: expStat, tag: tag});
  endtask

  // lower halfword current, upper holds a branch encoding
  task automatic lo(input logic [15:0] h, input logic [31:0] expWord,
                    input logic [1:0] expStat, input string tag);
    drive({16'hE000, h}, 1'b0, 1'b1, expWord, expStat, tag);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (fullInsn !== e.word || status !== e.stat) begin
        bad++;
        $display("FAIL %s: got word=%08h status=%0d, expected word=%08h status=%0d",
                 e.tag, fullInsn, status, e.word, e.stat);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog: got cycles=%0d, expected below %0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // reset state: all-zero fetch word is a shift by zero of r0
    drive(32'h0000_0000, 1'b0, 1'b0, 32'hE1B0_0000, 2'd0, "R2 reset");

    // R1 halfword select
    drive(32'hFFFF_00D1, 1'b0, 1'b0, 32'hE1B0_1182, 2'd0, "R1 lower");
    drive(32'h00D1_FFFF, 1'b1, 1'b0, 32'hE1B0_1182, 2'd0, "R1 upper");
    drive(32'hFFFF_00D1, 1'b1, 1'b0, FILL,          2'd2, "R1 upper-branch");

    // R2 shift by immediate
    lo(16'h17C7, 32'hE1B0_7FC0, 2'd0, "R2 asr");

    // R3 add/subtract
    lo(16'h1F63, 32'hE254_3005, 2'd0, "R3 sub-imm");
    lo(16'h1888, 32'hE091_0002, 2'd0, "R3 add-reg");

    // R4 immediate ops
    lo(16'h2EAB, 32'hE356_60AB, 2'd0, "R4 cmp");
    lo(16'h227F, 32'hE3B2_207F, 2'd0, "R4 mov");

    // R5 register ALU layouts
    lo(16'h4051, 32'hE031_1002, 2'd0, "R5 normal");
    lo(16'h41E3, 32'hE1B0_3473, 2'd0, "R5 shift");
    lo(16'h4275, 32'hE276_5000, 2'd0, "R5 negate");
    lo(16'h434F, 32'hE017_0791, 2'd0, "R5 multiply");

    // R6 high registers
    lo(16'h44E2, 32'hE08A_A00C, 2'd0, "R6 add-hi");
    lo(16'h4688, 32'hE1A8_8001, 2'd0, "R6 mov-hi");
    lo(16'h4770, 32'hE12F_FF1E, 2'd0, "R6 exchange");
    lo(16'h440A, FILL,          2'd1, "R6 undefined");

    // R7 link-exchange gated by v5Enable
    drive(32'hE000_4798, 1'b0, 1'b1, 32'hE120_0033, 2'd0, "R7 v5-on");
    drive(32'hE000_4798, 1'b0, 1'b0, FILL,          2'd1, "R7 v5-off");

    // R8 loads and stores
    lo(16'h4D10, 32'hE59F_5040, 2'd0, "R8 pc-load");
    lo(16'h5C88, 32'hE7D1_0002, 2'd0, "R8 reg-byte");
    lo(16'h5F63, 32'hE194_30F5, 2'd0, "R8 reg-signed-half");
    lo(16'h6951, 32'hE592_1014, 2'd0, "R8 imm-word");
    lo(16'h7151, 32'hE5C2_1005, 2'd0, "R8 imm-byte");
    lo(16'h8ED1, 32'hE1D2_13B6, 2'd0, "R8 half");
    lo(16'h9420, 32'hE58D_4080, 2'd0, "R8 sp-store");

    // R9 address generation and stack adjust
    lo(16'hA233, 32'hE28F_2F33, 2'd0, "R9 pc-addr");
    lo(16'hAE01, 32'hE28D_6F01, 2'd0, "R9 sp-addr");
    lo(16'hB0FF, 32'hE24D_DF7F, 2'd0, "R9 sp-sub");
    lo(16'hB005, 32'hE28D_DF05, 2'd0, "R9 sp-add");

    // R10 push/pop, multiple, interrupts
    lo(16'hB505, 32'hE92D_4005, 2'd0, "R10 push-lr");
    lo(16'hBD80, 32'hE8BD_8080, 2'd0, "R10 pop-pc");
    lo(16'hC302, 32'hE8A3_0002, 2'd0, "R10 store-multi");
    lo(16'hCB02, 32'hE8B3_0002, 2'd0, "R10 load-multi");
    lo(16'hDF42, 32'hEF00_0042, 2'd0, "R10 swi");
    lo(16'hBE12, 32'hEF18_0000, 2'd0, "R10 trap");

    // R11 branch classes, R12 filler and codes
    lo(16'hD000, FILL, 2'd2, "R11 cond-branch");
    lo(16'hDE00, FILL, 2'd1, "R11 cond-undef");
    lo(16'hE123, FILL, 2'd2, "R11 uncond");
    lo(16'hE801, FILL, 2'd1, "R11 c29-odd");
    lo(16'hE800, FILL, 2'd2, "R11 c29-even");
    lo(16'hF000, FILL, 2'd2, "R12 link-high");

    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule